// File: doc/BRIEF.md
# Per-Port Edge Event Capture with Service Marker

This block watches one group of debounced digital inputs (16 channels by default) on the system clock. It records qualified transitions into two sticky event registers, one for rising edges and one for falling edges. Each channel has its own rising enable bit and its own falling enable bit, so a channel can report rising edges only, falling edges only, or both. The port raises one edge marker while either register holds an event. The marker also drives an active-low pin.

A control side reads either register with a one-cycle strobe and a select bit. An accepted read returns a snapshot of the selected register. It then opens a two-clock window in which the marker is held low. When the window ends, the snapshot bits are cleared from the selected register. Edges that arrive during the window are queued and merged when the window closes, so none are lost. This holds even for a channel whose bit is being cleared. A service-pending flag follows the marker. It is set when the marker goes high, stays set through the forced-low window, and clears only when the marker is seen low outside a window.

Top module: `edge_evt_port`

## Requirements
- R1: Detection compares each channel's current sample with its previous sample. A 0-to-1 change on a channel with its rising enable set sets that bit of the rising register. A 1-to-0 change on a channel with its falling enable set sets that bit of the falling register. A change applied before clock edge k is visible in the register by edge k+1.
- R2: After reset both enable masks are zero, so no edge is recorded. A channel whose enable bit for a given polarity is 0 never records that polarity.
- R3: Event bits are sticky. They stay set until a read of their own register clears them.
- R4: An accepted read is rd_stb high while no window is running, with rd_sel 0 for the rising register and 1 for the falling register. It loads rd_data with that register's value in the strobe cycle, on the next clock edge. rd_data holds that value until the next accepted read, and it is zero after reset.
- R5: marker is high when either register is non-zero and no window is running. marker_n is always its inverse.
- R6: An accepted read forces marker low for exactly the two clock cycles after the strobe edge. In the following cycle, marker is high again if either register is still non-zero.
- R7: At the end of the window only the snapshot bits are cleared, and only in the selected register. The other register is untouched.
- R8: Qualified edges detected during the window are merged into their registers when the window ends. This includes a channel whose bit is being cleared by that read.
- R9: A strobe that arrives while a window is running is ignored. It changes neither rd_data nor either register.
- R10: pending is set one clock after marker rises and stays set through a forced-low window. It clears one clock after a cycle in which marker is low with no window running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| din | input | N_CH | Debounced channel inputs |
| mask_wdata | input | N_CH | Write data for either enable mask |
| rise_mask_we | input | 1 | Writes mask_wdata into the rising enable mask |
| fall_mask_we | input | 1 | Writes mask_wdata into the falling enable mask |
| rd_stb | input | 1 | Single-cycle read request |
| rd_sel | input | 1 | Register select: 0 rising, 1 falling |
| rd_data | output | N_CH | Snapshot returned by the last accepted read |
| marker | output | 1 | Edge marker, active high |
| marker_n | output | 1 | Edge marker for the external pin, active low |
| pending | output | 1 | Service-pending flag |

## Verification
The checker watches several properties on every cycle:
- marker is low in the cycle after an accepted read.
- A second strobe is never accepted inside the window.
- Event bits never drop outside the closing cycle of a window.
- rd_data changes only after an accepted read.
- pending rises after the marker and falls only after a low marker.

The directed scenarios cover what the checker cannot. They check the read values for each polarity mix and that the marker re-posts when the other register is still set. They also check that an edge queued on a channel being cleared survives, and that a strobe issued inside a window leaves both registers and rd_data as they were.

// File: rtl/edge_evt_pkg.sv
// Shared types for the edge event port.
// Assumes a one-bit register select on the read side.
package edge_evt_pkg;
    typedef enum logic {
        SEL_RISE = 1'b0,
        SEL_FALL = 1'b1
    } evt_sel_e;
endpackage

// File: rtl/edge_sampler.sv
// Samples the debounced inputs on the system clock and flags each
// channel's transitions by comparing the current and previous samples.
// Assumes inputs are already debounced and synchronous enough to sample.
module edge_sampler #(
    parameter int N_CH = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N_CH-1:0] din,
    output logic [N_CH-1:0] rise_raw,
    output logic [N_CH-1:0] fall_raw
);
    logic [N_CH-1:0] s_cur;
    logic [N_CH-1:0] s_prev;

    // Two-deep sample history per channel.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_cur  <= '0;
            s_prev <= '0;
        end else begin
            s_cur  <= din;
            s_prev <= s_cur;
        end
    end

    assign rise_raw = s_cur & ~s_prev;
    assign fall_raw = ~s_cur & s_prev;
endmodule

// File: rtl/edge_evt_bank.sv
// One polarity: enable mask, sticky event register, read snapshot and
// queue for edges that land inside a read window.
// Assumes cap, hold and done come from the read controller, with done
// high only in the final cycle of a window.
module edge_evt_bank #(
    parameter int N_CH = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N_CH-1:0] hit_raw,
    input  logic            mask_we,
    input  logic [N_CH-1:0] mask_wdata,
    input  logic            cap,
    input  logic            pick,
    input  logic            hold,
    input  logic            done,
    output logic [N_CH-1:0] ev
);
    logic [N_CH-1:0] mask;
    logic [N_CH-1:0] snap;
    logic [N_CH-1:0] queue;
    logic [N_CH-1:0] hit;

    assign hit = hit_raw & mask;

    // Enable mask, cleared at reset.
    always_ff @(posedge clk) begin
        if (!rst_n)       mask <= '0;
        else if (mask_we) mask <= mask_wdata;
    end

    // Snapshot of the events to clear; zero when the other bank is read.
    always_ff @(posedge clk) begin
        if (!rst_n)   snap <= '0;
        else if (cap) snap <= pick ? ev : '0;
    end

    // Queue and event register update across the window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ev    <= '0;
            queue <= '0;
        end else if (done) begin
            ev    <= (ev & ~snap) | queue | hit;
            queue <= '0;
        end else if (hold) begin
            queue <= queue | hit;
        end else begin
            ev    <= ev | hit;
        end
    end
endmodule

// File: rtl/edge_read_ctrl.sv
// Read controller. It accepts strobes, times the forced-low window,
// returns snapshots, and drives the marker and the pending flag.
// Assumes rd_stb is a single-cycle request; strobes inside a window
// are dropped.
module edge_read_ctrl
    import edge_evt_pkg::*;
#(
    parameter int N_CH     = 16,
    parameter int HOLD_CYC = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            rd_stb,
    input  evt_sel_e        rd_sel,
    input  logic [N_CH-1:0] rise_ev,
    input  logic [N_CH-1:0] fall_ev,
    output logic            accept,
    output logic            hold,
    output logic            done,
    output logic            rise_pick,
    output logic [N_CH-1:0] rd_data,
    output logic            marker,
    output logic            pending
);
    localparam int CW = $clog2(HOLD_CYC + 1);
    localparam logic [CW-1:0] HOLD_LD = CW'(HOLD_CYC);

    logic [CW-1:0] busy_cnt;

    assign hold      = (busy_cnt != '0);
    assign done      = (busy_cnt == CW'(1));
    assign accept    = rd_stb && !hold;
    assign rise_pick = (rd_sel == SEL_RISE);
    assign marker    = !hold && ((|rise_ev) || (|fall_ev));

    // Window counter: loaded on an accepted read, counts down to idle.
    always_ff @(posedge clk) begin
        if (!rst_n)      busy_cnt <= '0;
        else if (accept) busy_cnt <= HOLD_LD;
        else if (hold)   busy_cnt <= busy_cnt - CW'(1);
    end

    // Read data holds the snapshot of the selected register.
    always_ff @(posedge clk) begin
        if (!rst_n)      rd_data <= '0;
        else if (accept) rd_data <= rise_pick ? rise_ev : fall_ev;
    end

    // Pending: set by a live marker, cleared by a low marker outside a window.
    always_ff @(posedge clk) begin
        if (!rst_n)      pending <= 1'b0;
        else if (marker) pending <= 1'b1;
        else if (!hold)  pending <= 1'b0;
    end
endmodule

// File: rtl/edge_evt_port.sv
// Top of one edge event port: sampler, a rising bank, a falling bank
// generated from one bank module, and the read controller.
// Assumes debounced inputs and a simple strobe/select read interface.
module edge_evt_port
    import edge_evt_pkg::*;
#(
    parameter int N_CH     = 16,
    parameter int HOLD_CYC = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N_CH-1:0] din,
    input  logic [N_CH-1:0] mask_wdata,
    input  logic            rise_mask_we,
    input  logic            fall_mask_we,
    input  logic            rd_stb,
    input  logic            rd_sel,
    output logic [N_CH-1:0] rd_data,
    output logic            marker,
    output logic            marker_n,
    output logic            pending
);
    logic [N_CH-1:0] rise_raw, fall_raw;
    logic [N_CH-1:0] rise_ev, fall_ev;
    logic [1:0][N_CH-1:0] raw_v, ev_v;
    logic [1:0] we_v, pick_v;
    logic accept, hold, done, rise_pick;

    edge_sampler #(.N_CH(N_CH)) u_smp (
        .clk(clk), .rst_n(rst_n), .din(din),
        .rise_raw(rise_raw), .fall_raw(fall_raw)
    );

    assign raw_v  = {fall_raw, rise_raw};
    assign we_v   = {fall_mask_we, rise_mask_we};
    assign pick_v = {!rise_pick, rise_pick};

    for (genvar p = 0; p < 2; p++) begin : g_bank
        edge_evt_bank #(.N_CH(N_CH)) u_bank (
            .clk(clk), .rst_n(rst_n), .hit_raw(raw_v[p]),
            .mask_we(we_v[p]), .mask_wdata(mask_wdata),
            .cap(accept), .pick(pick_v[p]), .hold(hold), .done(done),
            .ev(ev_v[p])
        );
    end

    assign rise_ev = ev_v[0];
    assign fall_ev = ev_v[1];

    edge_read_ctrl #(.N_CH(N_CH), .HOLD_CYC(HOLD_CYC)) u_ctl (
        .clk(clk), .rst_n(rst_n), .rd_stb(rd_stb),
        .rd_sel(evt_sel_e'(rd_sel)),
        .rise_ev(rise_ev), .fall_ev(fall_ev),
        .accept(accept), .hold(hold), .done(done), .rise_pick(rise_pick),
        .rd_data(rd_data), .marker(marker), .pending(pending)
    );

    assign marker_n = !marker;
endmodule

// File: rtl/edge_evt_port_chk.sv
// Checker for the edge event port, bound to every instance of the top.
module edge_evt_port_chk #(
    parameter int N_CH = 16
) (
    input logic            clk,
    input logic            rst_n,
    input logic            accept,
    input logic            done,
    input logic            marker,
    input logic            pending,
    input logic [N_CH-1:0] rd_data,
    input logic [N_CH-1:0] rise_ev,
    input logic [N_CH-1:0] fall_ev
);
    // R6
    marker_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !marker);

    // R9
    no_reaccept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !accept);

    // R4
    rd_data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |=> $stable(rd_data));

    // R3
    rise_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done |=> (($past(rise_ev) & ~rise_ev) == '0));

    // R3
    fall_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done |=> (($past(fall_ev) & ~fall_ev) == '0));

    // R10
    pend_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(marker) |=> pending);

    // R10
    pend_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pending) |-> $past(!marker));
endmodule

bind edge_evt_port edge_evt_port_chk #(.N_CH(N_CH)) u_chk (
    .clk(clk), .rst_n(rst_n), .accept(accept), .done(done),
    .marker(marker), .pending(pending), .rd_data(rd_data),
    .rise_ev(rise_ev), .fall_ev(fall_ev)
);

// File: tb/edge_evt_port_tb.sv
module edge_evt_port_tb;
    localparam int CLK_P = 10;
    localparam int N = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] din = '0;
    logic [N-1:0] mask_wdata = '0;
    logic         rise_mask_we = 1'b0;
    logic         fall_mask_we = 1'b0;
    logic         rd_stb = 1'b0;
    logic         rd_sel = 1'b0;
    logic [N-1:0] rd_data;
    logic         marker, marker_n, pending;
    int           n_vec = 0;
    int           n_bad = 0;
    logic [N-1:0] got;

    always #(CLK_P/2) clk = ~clk;

    edge_evt_port #(.N_CH(N)) u_dut (
        .clk(clk), .rst_n(rst_n), .din(din), .mask_wdata(mask_wdata),
        .rise_mask_we(rise_mask_we), .fall_mask_we(fall_mask_we),
        .rd_stb(rd_stb), .rd_sel(rd_sel), .rd_data(rd_data),
        .marker(marker), .marker_n(marker_n), .pending(pending)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_masks(input logic [N-1:0] rm, input logic [N-1:0] fm);
        mask_wdata = rm; rise_mask_we = 1'b1; step(1);
        rise_mask_we = 1'b0;
        mask_wdata = fm; fall_mask_we = 1'b1; step(1);
        fall_mask_we = 1'b0;
    endtask

    // Accepted read; checks the forced-low window on the way (R6).
    task automatic rd(input logic sel, output logic [N-1:0] data);
        rd_stb = 1'b1; rd_sel = sel; step(1);
        rd_stb = 1'b0; data = rd_data;
        chk("R6 marker low 1st", marker, 0);
        chk("R5 marker_n inverse", marker_n, 1);
        step(1);
        chk("R6 marker low 2nd", marker, 0);
        step(1);
    endtask

    task automatic t_reset;
        chk("R4 rd_data reset", rd_data, 0);
        chk("R5 marker reset", marker, 0);
        chk("R5 marker_n reset", marker_n, 1);
        chk("R10 pending reset", pending, 0);
        din = 16'h0011; step(3);
        chk("R2 no event with reset masks", marker, 0);
        din = 16'h0000; step(3);
        chk("R2 no fall event with reset masks", marker, 0);
    endtask

    task automatic t_rise_only;
        wr_masks(16'hFFFF, 16'h0000);
        din = 16'h00F0; step(2);
        chk("R1 marker after rise", marker, 1);
        chk("R5 marker_n low", marker_n, 0);
        chk("R10 pending not yet", pending, 0);
        step(1);
        chk("R10 pending set", pending, 1);
        rd(1'b0, got);
        chk("R1 R4 rising read", got, 16'h00F0);
        chk("R6 marker stays low, both clear", marker, 0);
        chk("R10 pending held at window end", pending, 1);
        step(1);
        chk("R10 pending cleared", pending, 0);
        din = 16'h0000; step(3);
        chk("R2 disabled falling ignored", marker, 0);
    endtask

    task automatic t_both;
        wr_masks(16'hFFFF, 16'h000F);
        din = 16'h0003; step(2);
        din = 16'h0000; step(2);
        rd(1'b0, got);
        chk("R1 rise read both", got, 16'h0003);
        chk("R6 marker reposts for other register", marker, 1);
        chk("R10 pending stays", pending, 1);
        rd(1'b1, got);
        chk("R1 fall read", got, 16'h0003);
        chk("R7 marker low after both read", marker, 0);
        step(1);
        chk("R10 pending clears", pending, 0);
        rd(1'b0, got);
        chk("R7 rising cleared", got, 16'h0000);
    endtask

    task automatic t_sticky;
        din = 16'h0200; step(2);
        step(20);
        chk("R3 marker sticky", marker, 1);
        rd(1'b0, got);
        chk("R3 event sticky", got, 16'h0200);
        din = 16'h0000; step(3);
        chk("R2 ch9 fall disabled", marker, 0);
    endtask

    task automatic t_queue;
        din = 16'h0004; step(2);
        din = 16'h0000; step(2);
        rd_stb = 1'b1; rd_sel = 1'b0; din = 16'h0004; step(1);
        rd_stb = 1'b0;
        chk("R4 snapshot before queue", rd_data, 16'h0004);
        din = 16'h0084; step(1);
        chk("R6 low in window", marker, 0);
        step(1);
        chk("R8 marker after merge", marker, 1);
        rd(1'b0, got);
        chk("R8 queued edge survives clear", got, 16'h0084);
        rd(1'b1, got);
        chk("R7 fall untouched by rise read", got, 16'h0004);
        din = 16'h0000; step(2);
        rd(1'b1, got);
        chk("R1 ch2 fall only", got, 16'h0004);
        chk("R7 all clear", marker, 0);
    endtask

    task automatic t_ignore;
        din = 16'h0001; step(2);
        din = 16'h0000; step(2);
        rd(1'b0, got);
        chk("R1 ch0 rise", got, 16'h0001);
        din = 16'h0100; step(2);
        rd_stb = 1'b1; rd_sel = 1'b0; step(1);
        chk("R4 rise snapshot", rd_data, 16'h0100);
        rd_sel = 1'b1; step(1);
        rd_stb = 1'b0;
        chk("R9 rd_data unchanged", rd_data, 16'h0100);
        step(1);
        chk("R9 rd_data still unchanged", rd_data, 16'h0100);
        rd(1'b1, got);
        chk("R9 fall register not cleared", got, 16'h0001);
        rd(1'b0, got);
        chk("R7 rise cleared", got, 16'h0000);
        din = 16'h0000; step(3);
        chk("R2 ch8 fall disabled", marker, 0);
    endtask

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);
        t_reset();
        t_rise_only();
        t_both();
        t_sticky();
        t_queue();
        t_ignore();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_vec++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule